// File: doc/BRIEF.md
# Effective Address Generator Unit

This unit forms the 16-bit effective address for one operand of an 8-bit processor. The caller hands it an addressing-mode code, an access kind (read, store or read-modify-write), the program counter of the opcode byte and the two index registers. The unit then fetches the operand bytes that follow the opcode and, where the mode needs one, a pointer, through a synchronous byte-read port. It returns the effective address, a flag saying whether indexing stayed inside the base page, how many operand bytes the program counter must skip, and the base cycle count of the instruction.

The unit keeps the known quirks of the processor it serves. Zero-page indexing wraps within page zero. Pointer fetches from page zero wrap at its end. Indexed reads that cross a page cost one extra cycle. The indirect jump fetches its target high byte without carrying into the next page.

Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle, so a request held on the port while the unit is busy simply waits, and the caller may change the request fields freely until they are accepted. The fields are captured at acceptance. The result side is a plain one-cycle `done` strobe with no back-pressure; the caller must take the result in that cycle. The memory port returns `mem_rd_data` exactly one cycle after `mem_rd_en`, and at most one read is in flight.

Top module: `eff_addr_unit`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until the cycle in which `done` is high. `done` is high for exactly one cycle, N+2 cycles after the cycle in which the request was accepted, where N is the number of reads the mode needs. Request fields are sampled only at acceptance.
- R3: Mode codes on `req_mode` are 0 immediate, 1 zero page, 2 absolute, 3 zero page indexed by X, 4 zero page indexed by Y, 5 absolute indexed by X, 6 absolute indexed by Y, 7 indexed indirect (X), 8 indirect indexed (Y), and 9 absolute indirect jump. Reads are issued on consecutive cycles right after acceptance. The first operand byte is read at pc+1 and the second, if any, at pc+2. Pointer low and then high bytes follow, and the address is a 16-bit value of {high, low}.
- R4: In modes 3, 4 and 7, base byte plus index is truncated to 8 bits. The effective address of modes 3 and 4, and both pointer reads of mode 7 (at zp+X and zp+X+1), stay in page zero.
- R5: In mode 8 the pointer is read at zp and at (zp+1) mod 256.
- R6: In mode 9 the target low byte is read at ptr and the high byte at {ptr[15:8], ptr[7:0]+1 mod 256}.
- R7: In modes 5, 6 and 8, the index is added to the full 16-bit base with wrap at 0xFFFF. `same_page` is 1 when the low byte plus index does not exceed 0xFF. In every other mode `same_page` is 1.
- R8: `pc_step` is 2 for modes 2, 5, 6 and 9, and 1 otherwise.
- R9: Base cycles are 2 for immediate, 3 for zero page, 4 for absolute and zero-page indexed, 5 for absolute indexed and indirect jump, and 6 for both indirect modes.
- R10: `req_kind` codes are 0 read, 1 store, 2 read-modify-write, and 3 treated as read. A read-modify-write adds 2 cycles. A read in modes 5, 6 or 8 with `same_page` 1 takes one cycle less. A store keeps the base. The kind has no effect in modes 0 and 9.
- R11: Mode codes 10 to 15 behave exactly as immediate.
- R12: In immediate mode no read is issued and the effective address is pc+1 with wrap at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge if valid |
| req_mode | input | 4 | Addressing-mode code |
| req_kind | input | 2 | Access kind |
| req_pc | input | 16 | Address of the opcode byte |
| req_x | input | 8 | X index register |
| req_y | input | 8 | Y index register |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | 16 | Byte read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | Result valid strobe |
| ea | output | 16 | Effective address |
| same_page | output | 1 | Indexing did not cross a page |
| pc_step | output | 2 | Operand bytes after the opcode |
| cycles | output | 4 | Instruction cycle count |

## Verification
The assertions assume the memory returns a byte exactly one cycle after every read and never stalls. They also assume the result fields are meaningful only in the `done` cycle, and that the request recorded at acceptance is the one the next `done` answers. The bench memory model answers every read on the following edge. It drives requests away from clock edges and sometimes holds `req_valid` high with altered fields through a busy period, so refused requests are exercised without ever leaving a second request in flight.

// File: rtl/eau_pkg.sv
package eau_pkg;
  parameter int unsigned EA_DW = 8;
  parameter int unsigned EA_AW = 2 * EA_DW;
  parameter int unsigned EA_CW = 4;
  parameter int unsigned EA_NSLOT = 4;

  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_ZP   = 4'd1,
    M_ABS  = 4'd2,
    M_ZPX  = 4'd3,
    M_ZPY  = 4'd4,
    M_ABSX = 4'd5,
    M_ABSY = 4'd6,
    M_INDX = 4'd7,
    M_INDY = 4'd8,
    M_IND  = 4'd9
  } am_e;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_STORE = 2'd1,
    K_RMW   = 2'd2,
    K_ALT   = 2'd3
  } kind_e;

  // state value n (1..4) issues the read that fills byte slot n-1
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OP0  = 3'd1,
    ST_OP1  = 3'd2,
    ST_PT0  = 3'd3,
    ST_PT1  = 3'd4,
    ST_FIN  = 3'd5
  } st_e;

  localparam int unsigned SL_OP0 = 0;
  localparam int unsigned SL_OP1 = 1;
  localparam int unsigned SL_PT0 = 2;
  localparam int unsigned SL_PT1 = 3;

  localparam logic [EA_CW-1:0] CYC_IMM   = EA_CW'(2);
  localparam logic [EA_CW-1:0] CYC_ZP    = EA_CW'(3);
  localparam logic [EA_CW-1:0] CYC_ABS   = EA_CW'(4);
  localparam logic [EA_CW-1:0] CYC_ZPIX  = EA_CW'(4);
  localparam logic [EA_CW-1:0] CYC_ABSIX = EA_CW'(5);
  localparam logic [EA_CW-1:0] CYC_JIND  = EA_CW'(5);
  localparam logic [EA_CW-1:0] CYC_PTR   = EA_CW'(6);
  localparam logic [EA_CW-1:0] CYC_RMW   = EA_CW'(2);

  function automatic am_e decode_mode(input logic [3:0] code);
    if (code > 4'd9) return M_IMM;
    return am_e'(code);
  endfunction
endpackage

// File: rtl/eau_seq.sv
module eau_seq
  import eau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  am_e  mode,
  output st_e  state,
  output st_e  pend
);
  st_e state_q, state_d, pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = (mode == M_IMM) ? ST_FIN : ST_OP0;
      ST_OP0: begin
        unique case (mode)
          M_ABS, M_ABSX, M_ABSY, M_IND: state_d = ST_OP1;
          M_INDX, M_INDY:               state_d = ST_PT0;
          default:                      state_d = ST_FIN;
        endcase
      end
      ST_OP1:  state_d = (mode == M_IND) ? ST_PT0 : ST_FIN;
      ST_PT0:  state_d = ST_PT1;
      ST_PT1:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= ST_IDLE;
    end else begin
      state_q <= state_d;
      pend_q  <= state_q;
    end
  end

  assign state = state_q;
  assign pend  = pend_q;
endmodule

// File: rtl/eau_bytes.sv
module eau_bytes
  import eau_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  st_e                              pend,
  input  logic [EA_DW-1:0]                 rd_data,
  output logic [EA_NSLOT-1:0][EA_DW-1:0]   cur
);
  logic [EA_NSLOT-1:0][EA_DW-1:0] held_q;

  for (genvar i = 0; i < EA_NSLOT; i++) begin : g_slot
    logic hit;
    assign hit = (pend == st_e'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held_q[i] <= '0;
      else if (hit) held_q[i] <= rd_data;
    end

    // byte returning this cycle is forwarded without waiting for its register
    assign cur[i] = hit ? rd_data : held_q[i];
  end
endmodule

// File: rtl/eau_addr.sv
module eau_addr
  import eau_pkg::*;
(
  input  st_e                            state,
  input  am_e                            mode,
  input  logic [EA_AW-1:0]               pc,
  input  logic [EA_DW-1:0]               ix,
  input  logic [EA_NSLOT-1:0][EA_DW-1:0] bytes,
  output logic                           rd_en,
  output logic [EA_AW-1:0]               rd_addr
);
  localparam logic [EA_DW-1:0] PAGE0 = '0;

  logic [EA_DW-1:0] op0, op1, zp_ix;

  assign op0   = bytes[SL_OP0];
  assign op1   = bytes[SL_OP1];
  assign zp_ix = op0 + ix;

  always_comb begin
    rd_en   = 1'b1;
    rd_addr = '0;
    unique case (state)
      ST_OP0: rd_addr = pc + EA_AW'(1);
      ST_OP1: rd_addr = pc + EA_AW'(2);
      ST_PT0: begin
        unique case (mode)
          M_INDX:  rd_addr = {PAGE0, zp_ix};
          M_IND:   rd_addr = {op1, op0};
          default: rd_addr = {PAGE0, op0};
        endcase
      end
      ST_PT1: begin
        unique case (mode)
          M_INDX:  rd_addr = {PAGE0, EA_DW'(zp_ix + EA_DW'(1))};
          M_IND:   rd_addr = {op1, EA_DW'(op0 + EA_DW'(1))};
          default: rd_addr = {PAGE0, EA_DW'(op0 + EA_DW'(1))};
        endcase
      end
      default: rd_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/eau_result.sv
module eau_result
  import eau_pkg::*;
(
  input  am_e                            mode,
  input  kind_e                          kind,
  input  logic [EA_AW-1:0]               pc,
  input  logic [EA_DW-1:0]               x,
  input  logic [EA_DW-1:0]               y,
  input  logic [EA_NSLOT-1:0][EA_DW-1:0] bytes,
  output logic [EA_AW-1:0]               ea,
  output logic                           same_page,
  output logic [1:0]                     pc_step,
  output logic [EA_CW-1:0]               cycles
);
  localparam logic [EA_DW-1:0] PAGE0 = '0;

  logic [EA_DW-1:0] ix, lo, hi;
  logic [EA_DW:0]   lo_sum;
  logic [EA_CW-1:0] base;
  logic             sens;

  always_comb begin
    ix = (mode == M_ZPY || mode == M_ABSY || mode == M_INDY) ? y : x;
    lo = (mode == M_INDX || mode == M_INDY || mode == M_IND) ? bytes[SL_PT0] : bytes[SL_OP0];
    hi = (mode == M_INDX || mode == M_INDY || mode == M_IND) ? bytes[SL_PT1] : bytes[SL_OP1];
    lo_sum = {1'b0, lo} + {1'b0, ix};
  end

  always_comb begin
    ea        = {hi, lo};
    same_page = 1'b1;
    pc_step   = 2'd1;
    base      = CYC_IMM;
    sens      = 1'b0;
    unique case (mode)
      M_IMM: ea = pc + EA_AW'(1);
      M_ZP: begin
        ea   = {PAGE0, lo};
        base = CYC_ZP;
      end
      M_ZPX, M_ZPY: begin
        ea   = {PAGE0, lo_sum[EA_DW-1:0]};
        base = CYC_ZPIX;
      end
      M_ABS: begin
        pc_step = 2'd2;
        base    = CYC_ABS;
      end
      M_ABSX, M_ABSY, M_INDY: begin
        ea        = {hi, lo} + {PAGE0, ix};
        same_page = ~lo_sum[EA_DW];
        pc_step   = (mode == M_INDY) ? 2'd1 : 2'd2;
        base      = (mode == M_INDY) ? CYC_PTR : CYC_ABSIX;
        sens      = 1'b1;
      end
      M_INDX: base = CYC_PTR;
      M_IND: begin
        pc_step = 2'd2;
        base    = CYC_JIND;
      end
      default: ea = pc + EA_AW'(1);
    endcase
  end

  always_comb begin
    if (mode == M_IMM || mode == M_IND) begin
      cycles = base;
    end else begin
      unique case (kind)
        K_RMW:   cycles = base + CYC_RMW;
        K_STORE: cycles = base;
        default: cycles = base - EA_CW'(sens & same_page);
      endcase
    end
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3:0]           req_mode,
  input  logic [1:0]           req_kind,
  input  logic [EA_AW-1:0]     req_pc,
  input  logic [EA_DW-1:0]     req_x,
  input  logic [EA_DW-1:0]     req_y,
  output logic                 mem_rd_en,
  output logic [EA_AW-1:0]     mem_rd_addr,
  input  logic [EA_DW-1:0]     mem_rd_data,
  output logic                 done,
  output logic [EA_AW-1:0]     ea,
  output logic                 same_page,
  output logic [1:0]           pc_step,
  output logic [EA_CW-1:0]     cycles
);
  st_e                            state, pend;
  am_e                            mode_q, seq_mode;
  kind_e                          kind_q;
  logic [EA_AW-1:0]               pc_q;
  logic [EA_DW-1:0]               x_q, y_q, addr_ix;
  logic                           accept;
  logic [EA_NSLOT-1:0][EA_DW-1:0] bytes;
  logic [EA_AW-1:0]               r_ea;
  logic                           r_sp;
  logic [1:0]                     r_step;
  logic [EA_CW-1:0]               r_cyc;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  // in idle the sequencer picks its first step from the incoming code
  assign seq_mode  = (state == ST_IDLE) ? decode_mode(req_mode) : mode_q;
  assign addr_ix   = (mode_q == M_INDX) ? x_q : y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IMM;
      kind_q <= K_READ;
      pc_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (accept) begin
      mode_q <= decode_mode(req_mode);
      kind_q <= kind_e'(req_kind);
      pc_q   <= req_pc;
      x_q    <= req_x;
      y_q    <= req_y;
    end
  end

  eau_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .mode  (seq_mode),
    .state (state),
    .pend  (pend)
  );

  eau_bytes u_bytes (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .rd_data (mem_rd_data),
    .cur     (bytes)
  );

  eau_addr u_addr (
    .state   (state),
    .mode    (mode_q),
    .pc      (pc_q),
    .ix      (addr_ix),
    .bytes   (bytes),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_rd_addr)
  );

  eau_result u_result (
    .mode      (mode_q),
    .kind      (kind_q),
    .pc        (pc_q),
    .x         (x_q),
    .y         (y_q),
    .bytes     (bytes),
    .ea        (r_ea),
    .same_page (r_sp),
    .pc_step   (r_step),
    .cycles    (r_cyc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      ea        <= '0;
      same_page <= 1'b0;
      pc_step   <= '0;
      cycles    <= '0;
    end else begin
      done <= (state == ST_FIN);
      if (state == ST_FIN) begin
        ea        <= r_ea;
        same_page <= r_sp;
        pc_step   <= r_step;
        cycles    <= r_cyc;
      end
    end
  end
endmodule

// File: rtl/eau_checker.sv
module eau_checker
  import eau_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [3:0]           req_mode,
  input logic [1:0]           req_kind,
  input logic [EA_AW-1:0]     req_pc,
  input logic                 mem_rd_en,
  input logic                 done,
  input logic [EA_AW-1:0]     ea,
  input logic                 same_page,
  input logic [1:0]           pc_step,
  input logic [EA_CW-1:0]     cycles
);
  logic [3:0]       t_raw;
  logic [1:0]       t_kind;
  logic [EA_AW-1:0] t_pc;
  logic             t_zpage, t_indexed, t_two, t_imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_raw  <= '0;
      t_kind <= '0;
      t_pc   <= '0;
    end else if (req_valid && req_ready) begin
      t_raw  <= req_mode;
      t_kind <= req_kind;
      t_pc   <= req_pc;
    end
  end

  always_comb begin
    t_imm     = (t_raw == 4'd0) || (t_raw > 4'd9);
    t_zpage   = (t_raw == 4'd1) || (t_raw == 4'd3) || (t_raw == 4'd4);
    t_indexed = (t_raw == 4'd5) || (t_raw == 4'd6) || (t_raw == 4'd8);
    t_two     = (t_raw == 4'd2) || (t_raw == 4'd5) || (t_raw == 4'd6) || (t_raw == 4'd9);
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);
  a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !mem_rd_en));
  a_r4_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    (done && t_zpage) |-> (ea[EA_AW-1:EA_DW] == '0));
  a_r7_flat_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !t_indexed) |-> same_page);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_step == (t_two ? 2'd2 : 2'd1)));
  a_r9_zp_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (done && t_raw == 4'd1 && t_kind != 2'd2) |-> (cycles == EA_CW'(3)));
  a_r10_rmw_absx: assert property (@(posedge clk) disable iff (!rst_n)
    (done && t_raw == 4'd5 && t_kind == 2'd2) |-> (cycles == EA_CW'(7)));
  a_r11_r12_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (done && t_imm) |-> (ea == t_pc + EA_AW'(1) && cycles == EA_CW'(2)));
endmodule

bind eff_addr_unit eau_checker u_eau_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mode  (req_mode),
  .req_kind  (req_kind),
  .req_pc    (req_pc),
  .mem_rd_en (mem_rd_en),
  .done      (done),
  .ea        (ea),
  .same_page (same_page),
  .pc_step   (pc_step),
  .cycles    (cycles)
);

// File: tb/eff_addr_unit_bench.sv
`timescale 1ns/1ps
module eff_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_mode;
  logic [1:0]  req_kind;
  logic [15:0] req_pc;
  logic [7:0]  req_x;
  logic [7:0]  req_y;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        done;
  logic [15:0] ea;
  logic        same_page;
  logic [1:0]  pc_step;
  logic [3:0]  cycles;

  always #4 clk = ~clk;

  eff_addr_unit u_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_kind(req_kind), .req_pc(req_pc), .req_x(req_x),
    .req_y(req_y), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .done(done), .ea(ea), .same_page(same_page),
    .pc_step(pc_step), .cycles(cycles)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit run   = 0;
  bit act   = 0;
  int acc   = 0;
  int nrd   = 0;
  int eaddr [4];
  int e_ea, e_sp, e_step, e_cyc;
  string tag_ea, tag_rd, tag_cyc;
  int lst_ea, lst_sp, lst_step, lst_cyc;
  bit [7:0] mem_ovr [int];

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  function automatic int rdm(input int a);
    if (mem_ovr.exists(a)) return int'(mem_ovr[a]);
    return ((a * 29) ^ (a >> 8) ^ 'h5A) & 'hFF;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rd_data <= 8'(rdm(int'(mem_rd_addr)));
  end

  // behavioural reference: reads in order and final result from the requirements
  task automatic model(input int m, input int k, input int pc, input int x, input int y);
    int mm, b0, b1, p0, p1, idx, sp, cv;
    bit sens;
    mm = (m > 9) ? 0 : m;
    nrd = 0; sp = 1; e_step = 1; sens = 0; cv = 2;
    tag_ea = "R3"; tag_rd = "R3"; tag_cyc = "R9";
    case (mm)
      0: begin e_ea = (pc + 1) & 'hFFFF; cv = 2; tag_ea = (m > 9) ? "R11" : "R12"; end
      1: begin
        eaddr[0] = (pc + 1) & 'hFFFF; nrd = 1;
        e_ea = rdm(eaddr[0]); cv = 3;
      end
      3, 4: begin
        eaddr[0] = (pc + 1) & 'hFFFF; nrd = 1;
        idx = (mm == 3) ? x : y;
        e_ea = (rdm(eaddr[0]) + idx) & 'hFF; cv = 4; tag_ea = "R4";
      end
      2, 5, 6: begin
        eaddr[0] = (pc + 1) & 'hFFFF; eaddr[1] = (pc + 2) & 'hFFFF; nrd = 2;
        b0 = rdm(eaddr[0]); b1 = rdm(eaddr[1]);
        idx = (mm == 5) ? x : (mm == 6) ? y : 0;
        e_ea = (b1 * 256 + b0 + idx) & 'hFFFF;
        sp = ((b0 + idx) < 256) ? 1 : 0;
        e_step = 2; cv = (mm == 2) ? 4 : 5; sens = (mm != 2);
        if (sens) tag_ea = "R7";
      end
      7: begin
        eaddr[0] = (pc + 1) & 'hFFFF; b0 = rdm(eaddr[0]);
        eaddr[1] = (b0 + x) & 'hFF; eaddr[2] = (b0 + x + 1) & 'hFF; nrd = 3;
        p0 = rdm(eaddr[1]); p1 = rdm(eaddr[2]);
        e_ea = p1 * 256 + p0; cv = 6; tag_rd = "R4";
      end
      8: begin
        eaddr[0] = (pc + 1) & 'hFFFF; b0 = rdm(eaddr[0]);
        eaddr[1] = b0; eaddr[2] = (b0 + 1) & 'hFF; nrd = 3;
        p0 = rdm(eaddr[1]); p1 = rdm(eaddr[2]);
        e_ea = (p1 * 256 + p0 + y) & 'hFFFF;
        sp = ((p0 + y) < 256) ? 1 : 0;
        cv = 6; sens = 1; tag_rd = "R5"; tag_ea = "R7";
      end
      default: begin
        eaddr[0] = (pc + 1) & 'hFFFF; eaddr[1] = (pc + 2) & 'hFFFF;
        b0 = rdm(eaddr[0]); b1 = rdm(eaddr[1]);
        eaddr[2] = b1 * 256 + b0; eaddr[3] = b1 * 256 + ((b0 + 1) & 'hFF); nrd = 4;
        p0 = rdm(eaddr[2]); p1 = rdm(eaddr[3]);
        e_ea = p1 * 256 + p0; cv = 5; e_step = 2; tag_rd = "R6";
      end
    endcase
    if (mm != 0 && mm != 9) begin
      if (k == 2) begin cv += 2; tag_cyc = "R10"; end
      else if (k != 1 && sens && sp == 1) begin cv -= 1; tag_cyc = "R10"; end
    end
    e_cyc = cv; e_sp = sp;
  endtask

  // per-clock comparison against the reference
  bit exp_rdy, exp_rd, exp_done;
  always @(negedge clk) begin
    if (run) begin
      exp_rdy  = !act || (cyc <= acc) || (cyc >= acc + nrd + 2);
      exp_rd   = act && (cyc > acc) && (cyc <= acc + nrd);
      exp_done = act && (cyc == acc + nrd + 2);
      chk(req_ready == exp_rdy, "R2 ready", int'(req_ready), int'(exp_rdy));
      chk(mem_rd_en == exp_rd, "R3 read enable", int'(mem_rd_en), int'(exp_rd));
      if (exp_rd && mem_rd_en)
        chk(int'(mem_rd_addr) == eaddr[cyc - acc - 1], {tag_rd, " read address"},
            int'(mem_rd_addr), eaddr[cyc - acc - 1]);
      chk(done == exp_done, "R2 done timing", int'(done), int'(exp_done));
      if (exp_done && done) begin
        chk(int'(ea) == e_ea, {tag_ea, " effective address"}, int'(ea), e_ea);
        chk(int'(same_page) == e_sp, "R7 same page", int'(same_page), e_sp);
        chk(int'(pc_step) == e_step, "R8 pc step", int'(pc_step), e_step);
        chk(int'(cycles) == e_cyc, {tag_cyc, " cycles"}, int'(cycles), e_cyc);
        lst_ea = int'(ea); lst_sp = int'(same_page);
        lst_step = int'(pc_step); lst_cyc = int'(cycles);
      end
    end
  end

  task automatic issue(input int m, input int k, input int pc, input int x, input int y,
                       input bit hold);
    @(negedge clk); #1;
    model(m, k, pc, x, y);
    req_mode = 4'(m); req_kind = 2'(k); req_pc = 16'(pc); req_x = 8'(x); req_y = 8'(y);
    req_valid = 1'b1; act = 1'b1; acc = cyc;
    @(negedge clk); #1;
    if (!hold) req_valid = 1'b0;
    else begin
      req_mode = 4'($urandom_range(0, 15)); req_kind = 2'($urandom_range(0, 3));
      req_pc = 16'($urandom); req_x = 8'($urandom); req_y = 8'($urandom);
    end
    while (cyc < acc + nrd + 1) begin @(negedge clk); #1; end
    req_valid = 1'b0;
  endtask

  task automatic issue_chk(input int m, input int k, input int pc, input int x, input int y,
                           input int xea, input int xsp, input int xcyc, input string tag);
    issue(m, k, pc, x, y, 1'b0);
    @(negedge clk); #1;
    chk(lst_ea == xea, {tag, " directed address"}, lst_ea, xea);
    chk(lst_sp == xsp, {tag, " directed same page"}, lst_sp, xsp);
    chk(lst_cyc == xcyc, {tag, " directed cycles"}, lst_cyc, xcyc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_kind = '0;
    req_pc = '0; req_x = '0; req_y = '0;
    repeat (3) @(negedge clk);
    // R1: idle state under reset
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(mem_rd_en == 1'b0, "R1 no read in reset", int'(mem_rd_en), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_rd_en == 1'b0, "R1 idle after reset",
        int'({req_ready, done, mem_rd_en}), 4);
    run = 1'b1;

    // R12 immediate wraps; kind ignored (R10)
    issue_chk(0, 2, 'hFFFF, 0, 0, 'h0000, 1, 2, "R12");
    // R11 unused mode code behaves as immediate
    issue_chk(12, 2, 'h1234, 9, 9, 'h1235, 1, 2, "R11");
    // R4 zero page indexed wrap
    mem_ovr['h1001] = 8'hF0;
    issue_chk(3, 0, 'h1000, 'h20, 0, 'h0010, 1, 4, "R4");
    mem_ovr['h2001] = 8'hFF;
    issue_chk(4, 0, 'h2000, 0, 'h01, 'h0000, 1, 4, "R4");
    // R9 zero page base, R10 read-modify-write adds two
    issue_chk(1, 0, 'h2000, 0, 0, 'h00FF, 1, 3, "R9");
    issue_chk(1, 2, 'h2000, 0, 0, 'h00FF, 1, 5, "R10");
    // R7 / R10 absolute indexed without and with page cross
    mem_ovr['h3001] = 8'h10; mem_ovr['h3002] = 8'h40;
    issue_chk(5, 0, 'h3000, 'h05, 0, 'h4015, 1, 4, "R10");
    issue_chk(5, 1, 'h3000, 'h05, 0, 'h4015, 1, 5, "R10");
    issue_chk(5, 2, 'h3000, 'h05, 0, 'h4015, 1, 7, "R10");
    issue_chk(5, 3, 'h3000, 'h05, 0, 'h4015, 1, 4, "R10");
    mem_ovr['h3001] = 8'hF0;
    issue_chk(5, 0, 'h3000, 'h20, 0, 'h4110, 0, 5, "R7");
    mem_ovr['h3101] = 8'h80; mem_ovr['h3102] = 8'hFF;
    issue_chk(6, 0, 'h3100, 0, 'h90, 'h0010, 0, 5, "R7");
    // R4 indexed indirect pointer wraps in page zero
    mem_ovr['h4001] = 8'hF0; mem_ovr['h00FF] = 8'h34; mem_ovr['h0000] = 8'h12;
    issue_chk(7, 0, 'h4000, 'h0F, 0, 'h1234, 1, 6, "R4");
    // R5 indirect indexed pointer high byte wraps
    mem_ovr['h5001] = 8'hFF;
    issue_chk(8, 0, 'h5000, 0, 'h10, 'h1244, 1, 5, "R5");
    issue_chk(8, 0, 'h5000, 0, 'hD0, 'h1304, 0, 6, "R5");
    issue_chk(8, 1, 'h5000, 0, 'hD0, 'h1304, 0, 6, "R10");
    issue_chk(8, 2, 'h5000, 0, 'h10, 'h1244, 1, 8, "R10");
    // R6 indirect jump stays within pointer page; kind ignored
    mem_ovr['h6001] = 8'hFF; mem_ovr['h6002] = 8'h70;
    mem_ovr['h70FF] = 8'hCD; mem_ovr['h7000] = 8'hAB; mem_ovr['h7100] = 8'hEE;
    issue_chk(9, 2, 'h6000, 0, 0, 'hABCD, 1, 5, "R6");
    // R2 request held while busy with changing fields is not taken again
    issue(7, 0, 'h4000, 'h0F, 0, 1'b1);
    issue(2, 2, 'h8000, 0, 0, 1'b1);
    // R2 back-to-back requests
    issue(0, 0, 'h0100, 0, 0, 1'b0);
    issue(1, 1, 'h0200, 0, 0, 1'b0);
    // mixed stimulus, all modes, kinds and unused codes (R3, R8)
    for (int i = 0; i < 400; i++)
      issue($urandom_range(0, 15), $urandom_range(0, 3), $urandom, $urandom_range(0, 255),
            $urandom_range(0, 255), 1'($urandom_range(0, 1)));
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule